// File: doc/BRIEF.md
# Key Matrix Scanning Encoder

This block reads a switch matrix of up to five rows by four columns and reports one pressed key as a binary code. It pulls one column low at a time in a fixed repeating order and watches the active-low row lines. When a row goes low, the scan stops on the current column and a debounce timer starts. When the timer expires the key code is latched and a data-available flag rises.

Every register moves only on a scan tick, which is a clock enable from the surrounding logic. This tick sets both the scan rate and the debounce time unit. A key is recognised once. The encoder then waits for that same key to be released and for the release to pass its own debounce. Only then does scanning resume, so a second key held down in the meantime is ignored. The code output is a value plus a qualifier that stands in for a tri-state bus. An active-low output-enable input gates both.

Top module: `key_scan_encoder`

## Requirements
- R1: After reset, column 0 is driven and `col_no` is 4'b1110. While no row is low, each scan tick moves the single low column one step in the order 0, 1, 2, 3, 0, with column k driven by `col_no[k]` = 0.
- R2: In a cycle where `scan_tick_i` is low, no state changes: the column, the flag and the code stay as they are.
- R3: A scan tick that sees any row low freezes the column. That column stays driven until the key has been released and the release debounce has finished.
- R4: The row seen low on the detecting tick is locked. `dav_o` rises on the tick that completes DEBOUNCE_TICKS further consecutive ticks with that row still low. With a key already closed on column 0 after reset, `dav_o` is 0 after DEBOUNCE_TICKS ticks and 1 after DEBOUNCE_TICKS+1 ticks.
- R5: If the locked row is high on a tick before the press debounce completes, the encoder returns to scanning with `dav_o` low. Any later press needs a fresh full debounce.
- R6: The latched code is row_index*4 + column_index, with rows numbered 0 to NUM_ROWS-1 and columns 0 to 3. The code is 5 bits wide for five rows and 4 bits for four. When several rows in the driven column are low on the detecting tick, the lowest-numbered row is taken.
- R7: `dav_o` falls on the first tick that sees the locked row high after the key was accepted. The latched code keeps its value.
- R8: After release, the column stays frozen and no closure is recognised until the locked row has been high for DEBOUNCE_TICKS consecutive ticks. A low seen on the locked row during that window restarts the window and produces no new key.
- R9: While a key is locked, other keys have no effect: the code, the flag and the frozen column stay the same.
- R10: While `oe_ni` is 0, `code_o` carries the latched code and `code_valid_o` is 1. While `oe_ni` is 1, `code_o` is 0 and `code_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_tick_i | input | 1 | Scan and debounce time step (clock enable) |
| row_ni | input | NUM_ROWS | Row lines, active low |
| col_no | output | NUM_COLS | Column drive, the driven column low |
| oe_ni | input | 1 | Output enable, active low |
| code_o | output | CODE_W | Latched key code, zero when disabled |
| code_valid_o | output | 1 | High when `code_o` is driven |
| dav_o | output | 1 | Data available |

## Verification
The bench builds the encoder with five rows and a debounce of four ticks. The five rows make the 5-bit code and the top row index 4 reachable, including code 19. The short debounce keeps every press and release window within a few ticks. This allows exact tick counts for press acceptance, bounce recovery, release lockout and two-key roll-over. A behavioural key matrix in the bench pulls a row low only while the matching column is driven. This makes the same-column priority and the frozen-column lockout visible at the ports.

// File: rtl/kse_pkg.sv
package kse_pkg;
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_PRESS = 2'd1,
    ST_HELD  = 2'd2,
    ST_REL   = 2'd3
  } kse_state_e;
endpackage

// File: rtl/kse_col_scan.sv
module kse_col_scan #(
  parameter int NUM_COLS = 4,
  localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                freeze_i,
  output logic [COL_W-1:0]    col_idx_o,
  output logic [NUM_COLS-1:0] col_no
);
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
    end else if (tick_i && !freeze_i) begin
      if (col_q == COL_W'(NUM_COLS - 1)) col_q <= '0;
      else                                col_q <= col_q + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_dec
    assign col_no[c] = (col_q != COL_W'(c));
  end

  assign col_idx_o = col_q;

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(col_q)); // R2
  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(col_q)); // R3
endmodule

// File: rtl/kse_row_pick.sv
module kse_row_pick #(
  parameter int NUM_ROWS = 5,
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic [NUM_ROWS-1:0] row_ni,
  output logic                any_low_o,
  output logic [ROW_W-1:0]    row_idx_o
);
  // descending walk: lowest low row is written last and wins
  always_comb begin
    any_low_o = ~&row_ni;
    row_idx_o = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--) begin
      if (!row_ni[r]) row_idx_o = ROW_W'(r);
    end
  end
endmodule

// File: rtl/kse_debounce.sv
module kse_debounce
  import kse_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 4,
  localparam int CNT_W = $clog2(DEBOUNCE_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       lock_low_i,
  output kse_state_e state_o,
  output logic       load_o,
  output logic       dav_o
);
  kse_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dav_q;
  logic             cnt_done;

  assign cnt_done = (cnt_q == CNT_W'(DEBOUNCE_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SCAN;
      cnt_q   <= '0;
      dav_q   <= 1'b0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_SCAN: if (start_i) begin
          state_q <= ST_PRESS;
          cnt_q   <= '0;
        end
        ST_PRESS: begin
          if (!lock_low_i) begin
            state_q <= ST_SCAN;
            cnt_q   <= '0;
          end else if (cnt_done) begin
            state_q <= ST_HELD;
            cnt_q   <= '0;
            dav_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HELD: if (!lock_low_i) begin
          state_q <= ST_REL;
          cnt_q   <= '0;
          dav_q   <= 1'b0;
        end
        ST_REL: begin
          if (lock_low_i) begin
            cnt_q <= '0; // release bounce restarts the window
          end else if (cnt_done) begin
            state_q <= ST_SCAN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_SCAN;
      endcase
    end
  end

  assign load_o  = tick_i && (state_q == ST_PRESS) && lock_low_i && cnt_done;
  assign state_o = state_q;
  assign dav_o   = dav_q;

  AST_DAV_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dav_q) |-> $past(tick_i && lock_low_i)); // R4
  AST_DAV_FALL_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dav_q) |-> $past(tick_i && !lock_low_i)); // R7
endmodule

// File: rtl/key_scan_encoder.sv
module key_scan_encoder
  import kse_pkg::*;
#(
  parameter int NUM_ROWS       = 5,
  parameter int NUM_COLS       = 4,
  parameter int DEBOUNCE_TICKS = 4,
  localparam int ROW_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int COL_W  = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int CODE_W = ROW_W + COL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scan_tick_i,
  input  logic [NUM_ROWS-1:0] row_ni,
  output logic [NUM_COLS-1:0] col_no,
  input  logic                oe_ni,
  output logic [CODE_W-1:0]   code_o,
  output logic                code_valid_o,
  output logic                dav_o
);
  kse_state_e        state;
  logic              any_low;
  logic [ROW_W-1:0]  row_idx;
  logic [COL_W-1:0]  col_idx;
  logic [ROW_W-1:0]  lock_row_q;
  logic [CODE_W-1:0] code_q;
  logic              lock_low;
  logic              load;
  logic              detect;
  logic              freeze;

  assign detect   = scan_tick_i && (state == ST_SCAN) && any_low;
  assign freeze   = (state != ST_SCAN) || any_low;
  assign lock_low = !row_ni[lock_row_q];

  kse_row_pick #(.NUM_ROWS(NUM_ROWS)) i_row_pick (
    .row_ni    (row_ni),
    .any_low_o (any_low),
    .row_idx_o (row_idx)
  );

  kse_col_scan #(.NUM_COLS(NUM_COLS)) i_col_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (scan_tick_i),
    .freeze_i  (freeze),
    .col_idx_o (col_idx),
    .col_no    (col_no)
  );

  kse_debounce #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) i_debounce (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (scan_tick_i),
    .start_i    (any_low),
    .lock_low_i (lock_low),
    .state_o    (state),
    .load_o     (load),
    .dav_o      (dav_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_row_q <= '0;
      code_q     <= '0;
    end else begin
      if (detect) lock_row_q <= row_idx;
      if (load)   code_q     <= {lock_row_q, col_idx};
    end
  end

  assign code_o       = oe_ni ? '0 : code_q;
  assign code_valid_o = !oe_ni;

  AST_CODE_ONLY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> $past(load)); // R6
  AST_HELD_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HELD) |=> $stable(code_q) && $stable(col_no)); // R9
endmodule

// File: tb/test_key_scan_encoder.sv
module test_key_scan_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 5;
  localparam int NC = 4;
  localparam int DB = 4;
  localparam int CW = 5;
  localparam int NVEC = 6;
  // {row mask[4:0], column[1:0], expected code[4:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {5'b00001, 2'd0, 5'd0},
    {5'b00010, 2'd3, 5'd7},
    {5'b00100, 2'd1, 5'd9},
    {5'b10000, 2'd3, 5'd19},
    {5'b01010, 2'd2, 5'd6},
    {5'b11000, 2'd0, 5'd12}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic oe_n = 1'b0;
  logic [NR-1:0] row_n;
  logic [NC-1:0] col_n;
  logic [CW-1:0] code;
  logic code_valid, dav;
  logic [NR-1:0][NC-1:0] keys = '0;
  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int r = 0; r < NR; r++) row_n[r] = !(|(keys[r] & ~col_n));
  end

  key_scan_encoder #(.NUM_ROWS(NR), .NUM_COLS(NC), .DEBOUNCE_TICKS(DB)) i_key_scan_encoder (
    .clk_i(clk), .rst_ni(rst_n), .scan_tick_i(tick), .row_ni(row_n), .col_no(col_n),
    .oe_ni(oe_n), .code_o(code), .code_valid_o(code_valid), .dav_o(dav)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    keys = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk) cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [NC-1:0] col_prev;
    do_reset();
    // R1 reset state
    check(col_n == 4'b1110, "R1 reset column", col_n, 4'b1110);
    check(dav == 1'b0, "R1 reset dav", dav, 0);
    check(code == '0 && code_valid, "R10 reset code", code, 0);
    // R2 no tick, no motion
    repeat (5) @(negedge clk);
    check(col_n == 4'b1110, "R2 column without tick", col_n, 4'b1110);
    // R1 scan order
    for (int k = 1; k <= 5; k++) begin
      ticks(1);
      check(col_n == ~(4'b0001 << (k % 4)), "R1 scan order", col_n, ~(4'b0001 << (k % 4)));
    end

    // table: R6 codes, R3 freeze, R7 clear
    for (int v = 0; v < NVEC; v++) begin
      for (int r = 0; r < NR; r++) keys[r][VEC[v][6:5]] = VEC[v][11 - (4 - r)];
      ticks(4 + DB + 2);
      check(dav == 1'b1, "R4 accepted", dav, 1);
      check(code == VEC[v][4:0], "R6 key code", code, VEC[v][4:0]);
      check(col_n == ~(4'b0001 << VEC[v][6:5]), "R3 frozen column", col_n, ~(4'b0001 << VEC[v][6:5]));
      keys = '0;
      ticks(1);
      check(dav == 1'b0, "R7 dav clears", dav, 0);
      check(code == VEC[v][4:0], "R7 code kept", code, VEC[v][4:0]);
      ticks(DB + 2);
    end

    // R4 exact debounce length
    do_reset();
    keys[2][0] = 1'b1;
    ticks(DB);
    check(dav == 1'b0, "R4 before window end", dav, 0);
    ticks(1);
    check(dav == 1'b1, "R4 at window end", dav, 1);
    check(code == 5'd8, "R6 code row2 col0", code, 8);
    // R8 release: frozen through DEBOUNCE_TICKS+1 ticks, then scans
    keys = '0;
    ticks(DB + 1);
    check(col_n == 4'b1110, "R8 frozen during release", col_n, 4'b1110);
    ticks(1);
    check(col_n == 4'b1101, "R8 scan resumes", col_n, 4'b1101);

    // R5 bounce during press
    do_reset();
    keys[1][2] = 1'b1;
    ticks(3);
    check(col_n == 4'b1011, "R3 freeze on detect", col_n, 4'b1011);
    ticks(2);
    keys = '0;
    ticks(2);
    check(dav == 1'b0, "R5 bounce no key", dav, 0);
    check(col_n == 4'b0111, "R5 scan restarted", col_n, 4'b0111);
    keys[1][2] = 1'b1;
    ticks(4 + DB + 1);
    check(dav == 1'b1 && code == 5'd6, "R5 re-press accepted", code, 6);
    keys = '0;
    ticks(DB + 3);

    // R9 roll-over
    do_reset();
    keys[2][1] = 1'b1;
    ticks(2 + DB);
    check(dav == 1'b1 && code == 5'd9, "R9 first key", code, 9);
    keys[0][1] = 1'b1;
    keys[1][3] = 1'b1;
    ticks(3 * DB);
    check(code == 5'd9, "R9 second key ignored", code, 9);
    check(dav == 1'b1, "R9 dav held", dav, 1);
    check(col_n == 4'b1101, "R9 column held", col_n, 4'b1101);
    keys[2][1] = 1'b0;
    ticks(1);
    check(dav == 1'b0 && code == 5'd9, "R7 clear on release", dav, 0);
    ticks(DB + 1 + DB);
    check(dav == 1'b1 && code == 5'd1, "R9 next key after release", code, 1);

    // R8 release bounce
    keys = '0;
    ticks(3);
    keys[0][1] = 1'b1;
    ticks(3 * DB);
    check(dav == 1'b0, "R8 release bounce no key", dav, 0);
    check(col_n == 4'b1101, "R8 column still frozen", col_n, 4'b1101);
    keys = '0;
    ticks(DB - 1);
    check(col_n == 4'b1101, "R8 window restarted", col_n, 4'b1101);
    ticks(2);
    check(col_n == 4'b1011, "R8 scan after window", col_n, 4'b1011);

    // R10 output enable
    @(negedge clk) oe_n = 1'b1;
    #1 check(code == '0 && !code_valid, "R10 disabled", code, 0);
    @(negedge clk) oe_n = 1'b0;
    #1 check(code == 5'd1 && code_valid, "R10 enabled", code, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule